// File: doc/BRIEF.md
# Radix-2 Butterfly Index Scheduler

This block walks the complete pass structure of an in-place radix-2 decimation-in-time FFT and produces, one per cycle, the addresses that a butterfly datapath needs. Each output item holds three numbers: the index of the lower operand, the index of the upper operand, and an index into a table of twiddle factors. The block never touches data or twiddle values. A downstream unit reads both operands and the twiddle entry, forms `low + high*w` and `low - high*w`, and writes them back to the same two locations.

The vector length N is a power of two from 2 up to `2**MAX_LOG2`. A caller selects it through a log2 code that is captured only on an accepted start pulse. Items leave over a valid/ready handshake, and the last item of the run carries a flag. Indices address the vector in natural order, because the block applies no bit-reversed permutation. Passes run from the narrowest span (2) to the widest (N). Inside a pass, groups run in ascending base order and pairs run in ascending order inside a group. The twiddle index starts again at zero in every group.

Top module: `bfs_sched`

## Requirements
- R1: After reset, `valid_o` and `last_o` are low until a start is accepted.
- R2: A start pulse while idle, with a log2 code from 1 to MAX_LOG2, raises `valid_o` in the next cycle. The first item is low 0, high 1, twiddle 0.
- R3: The items follow this order. Passes go with span 2, 4, and so on up to N. Inside a pass, group bases go upward from 0 in steps of the span. Inside a group, j goes upward over span/2 values from the base. Each item has low = j and high = j + span/2.
- R4: The twiddle index is 0 on the first pair of every group and grows by N/span on each further pair of that group.
- R5: While `valid_o` is high and `ready_i` is low, the next cycle shows the same item with `valid_o` still high. The sequence moves on only when both are high at a clock edge.
- R6: `last_o` is high only with `valid_o`, and only on the final item (span N, low N/2-1, high N-1, twiddle N/2-1). A run has exactly (N/2)*log2(N) handshakes.
- R7: After the handshake that carries `last_o`, `valid_o` is low in the next cycle.
- R8: A start pulse during a run, with any code, is ignored and the running sequence is not disturbed.
- R9: A start pulse while idle with a log2 code of 0 or above MAX_LOG2 is ignored, and `valid_o` stays low.
- R10: The log2 code is sampled only when a start is accepted. Changing `log2n_i` during a run has no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, one cycle |
| log2n_i | input | CFG_W | log2 of the vector length, captured on an accepted start |
| ready_i | input | 1 | Consumer can take the current item |
| valid_o | output | 1 | Current item is valid |
| lo_idx_o | output | MAX_LOG2 | Lower operand index |
| hi_idx_o | output | MAX_LOG2 | Upper operand index |
| tw_idx_o | output | max(MAX_LOG2-1,1) | Twiddle table index |
| last_o | output | 1 | Current item is the final one of the run |

## Verification
The first item of a run appears one cycle after the edge that accepts the start. Each later item appears one cycle after the edge on which its predecessor was taken. `valid_o` drops one cycle after the edge that takes the flagged item. The bench drives inputs one nanosecond after a rising edge and samples every output at the following falling edge, so each check looks at the cycle in which the result is due. A scoreboard queue, filled from a loop-nest model, is compared on each falling-edge handshake. A stalled item is compared with its value at the previous falling edge. A second instance using the accumulating twiddle variant is checked against the first.

// File: rtl/bfs_pkg.sv
package bfs_pkg;
   localparam int TW_SHIFT = 0;
   localparam int TW_ACCUM = 1;

   function automatic int tw_width(input int max_log2);
      return (max_log2 > 1) ? max_log2 - 1 : 1;
   endfunction
endpackage

// File: rtl/bfs_stage_ctr.sv
module bfs_stage_ctr #(
   parameter int CFG_W = 3
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CFG_W-1:0] log2n,
   input  logic             adv,
   output logic [CFG_W-1:0] stage,
   output logic [CFG_W-1:0] nlog,
   output logic             final_stage
);
   logic [CFG_W-1:0] stage_q;
   logic [CFG_W-1:0] nlog_q;

   assign final_stage = (stage_q == (nlog_q - CFG_W'(1)));
   assign stage       = stage_q;
   assign nlog        = nlog_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= '0;
         nlog_q  <= '0;
      end else if (load) begin
         stage_q <= '0;
         nlog_q  <= log2n;
      end else if (adv && !final_stage) begin
         stage_q <= stage_q + CFG_W'(1);
      end
   end
endmodule

// File: rtl/bfs_pair_ctr.sv
module bfs_pair_ctr #(
   parameter int IDX_W = 6,
   parameter int CFG_W = 3
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             step,
   input  logic [CFG_W-1:0] stage,
   input  logic [CFG_W-1:0] nlog,
   output logic [IDX_W-1:0] lo,
   output logic [IDX_W-1:0] hi,
   output logic [IDX_W-1:0] off,
   output logic             off_last,
   output logic             grp_last
);
   logic [IDX_W-1:0] grp_q;
   logic [IDX_W-1:0] off_q;
   logic [IDX_W:0]   half_w;
   logic [IDX_W:0]   size_w;
   logic [IDX_W:0]   n_w;

   assign half_w   = (IDX_W+1)'(1) << stage;
   assign size_w   = half_w << 1;
   assign n_w      = (IDX_W+1)'(1) << nlog;
   assign off_last = (({1'b0, off_q} + (IDX_W+1)'(1)) == half_w);
   assign grp_last = (({1'b0, grp_q} + size_w) == n_w);

   // group base is a multiple of the span and the offset is below half of
   // it, so the fields never overlap and OR replaces an adder
   assign lo  = grp_q | off_q;
   assign hi  = lo | half_w[IDX_W-1:0];
   assign off = off_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grp_q <= '0;
         off_q <= '0;
      end else if (load) begin
         grp_q <= '0;
         off_q <= '0;
      end else if (step) begin
         if (off_last) begin
            off_q <= '0;
            if (grp_last) grp_q <= '0;
            else          grp_q <= grp_q + size_w[IDX_W-1:0];
         end else begin
            off_q <= off_q + IDX_W'(1);
         end
      end
   end
endmodule

// File: rtl/bfs_tw_shift.sv
module bfs_tw_shift #(
   parameter int IDX_W = 6,
   parameter int TW_W  = 5,
   parameter int CFG_W = 3
)(
   input  logic [IDX_W-1:0] off,
   input  logic [CFG_W-1:0] stage,
   input  logic [CFG_W-1:0] nlog,
   output logic [TW_W-1:0]  tw
);
   logic [CFG_W-1:0] shamt;

   // stride N/span equals 2**(log2N - 1 - stage); offset times stride
   assign shamt = nlog - CFG_W'(1) - stage;
   assign tw    = TW_W'(off << shamt);
endmodule

// File: rtl/bfs_tw_accum.sv
module bfs_tw_accum #(
   parameter int TW_W  = 5,
   parameter int CFG_W = 3
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             step,
   input  logic             off_last,
   input  logic [CFG_W-1:0] stage,
   input  logic [CFG_W-1:0] nlog,
   output logic [TW_W-1:0]  tw
);
   logic [TW_W-1:0]  acc_q;
   logic [TW_W-1:0]  stride;
   logic [CFG_W-1:0] shamt;

   assign shamt  = nlog - CFG_W'(1) - stage;
   assign stride = TW_W'(1) << shamt;
   assign tw     = acc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           acc_q <= '0;
      else if (load)        acc_q <= '0;
      else if (step) begin
         if (off_last)      acc_q <= '0;
         else               acc_q <= acc_q + stride;
      end
   end
endmodule

// File: rtl/bfs_sched.sv
module bfs_sched
   import bfs_pkg::*;
#(
   parameter int MAX_LOG2 = 6,
   parameter int CFG_W    = 3,
   parameter int TW_MODE  = TW_SHIFT,
   localparam int IDX_W   = MAX_LOG2,
   localparam int TW_W    = tw_width(MAX_LOG2)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [CFG_W-1:0] log2n_i,
   input  logic             ready_i,
   output logic             valid_o,
   output logic [IDX_W-1:0] lo_idx_o,
   output logic [IDX_W-1:0] hi_idx_o,
   output logic [TW_W-1:0]  tw_idx_o,
   output logic             last_o
);
   initial begin
      if (MAX_LOG2 < 1)
         $fatal(1, "bfs_sched: MAX_LOG2 must be at least 1");
      if (MAX_LOG2 >= (1 << CFG_W))
         $fatal(1, "bfs_sched: CFG_W too narrow for MAX_LOG2");
      if (TW_MODE != TW_SHIFT && TW_MODE != TW_ACCUM)
         $fatal(1, "bfs_sched: unknown TW_MODE");
   end

   logic             busy_q;
   logic             cfg_ok;
   logic             launch;
   logic             step;
   logic             final_stage;
   logic             off_last;
   logic             grp_last;
   logic [CFG_W-1:0] stage;
   logic [CFG_W-1:0] nlog;
   logic [IDX_W-1:0] off;

   assign cfg_ok = (log2n_i != '0) && (32'(log2n_i) <= 32'(MAX_LOG2));
   assign launch = start_i && !busy_q && cfg_ok;
   assign step   = busy_q && ready_i;
   assign valid_o = busy_q;
   assign last_o  = busy_q && final_stage && grp_last && off_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 busy_q <= 1'b0;
      else if (launch)            busy_q <= 1'b1;
      else if (step && last_o)    busy_q <= 1'b0;
   end

   bfs_stage_ctr #(.CFG_W(CFG_W)) stage_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .load        (launch),
      .log2n       (log2n_i),
      .adv         (step && off_last && grp_last),
      .stage       (stage),
      .nlog        (nlog),
      .final_stage (final_stage)
   );

   bfs_pair_ctr #(.IDX_W(IDX_W), .CFG_W(CFG_W)) pair_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (launch),
      .step     (step),
      .stage    (stage),
      .nlog     (nlog),
      .lo       (lo_idx_o),
      .hi       (hi_idx_o),
      .off      (off),
      .off_last (off_last),
      .grp_last (grp_last)
   );

   generate
      if (TW_MODE == TW_ACCUM) begin : g_tw_accum
         bfs_tw_accum #(.TW_W(TW_W), .CFG_W(CFG_W)) tw_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (launch),
            .step     (step),
            .off_last (off_last),
            .stage    (stage),
            .nlog     (nlog),
            .tw       (tw_idx_o)
         );
      end else begin : g_tw_shift
         bfs_tw_shift #(.IDX_W(IDX_W), .TW_W(TW_W), .CFG_W(CFG_W)) tw_i (
            .off   (off),
            .stage (stage),
            .nlog  (nlog),
            .tw    (tw_idx_o)
         );
      end
   endgenerate
endmodule

// File: rtl/bfs_sched_chk.sv
module bfs_sched_chk #(
   parameter int MAX_LOG2 = 6,
   parameter int CFG_W    = 3,
   parameter int IDX_W    = 6,
   parameter int TW_W     = 5
)(
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic [CFG_W-1:0] log2n_i,
   input logic             ready_i,
   input logic             valid_o,
   input logic [IDX_W-1:0] lo_idx_o,
   input logic [IDX_W-1:0] hi_idx_o,
   input logic [TW_W-1:0]  tw_idx_o,
   input logic             last_o
);
   AST_IDLE_NO_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      last_o |-> valid_o); // R6

   AST_FIRST_ITEM: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(valid_o) |-> (lo_idx_o == '0) && (hi_idx_o == IDX_W'(1)) && (tw_idx_o == '0)); // R2

   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o && !ready_i |=> valid_o && $stable(lo_idx_o) && $stable(hi_idx_o)
                             && $stable(tw_idx_o) && $stable(last_o)); // R5

   AST_HI_ABOVE_LO: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> hi_idx_o > lo_idx_o); // R3

   AST_END_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o && ready_i && last_o |=> !valid_o); // R7

   AST_BAD_CFG: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o && start_i && ((log2n_i == '0) || (32'(log2n_i) > 32'(MAX_LOG2)))
      |=> !valid_o); // R9
endmodule

bind bfs_sched bfs_sched_chk #(
   .MAX_LOG2 (MAX_LOG2),
   .CFG_W    (CFG_W),
   .IDX_W    (IDX_W),
   .TW_W     (TW_W)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .start_i  (start_i),
   .log2n_i  (log2n_i),
   .ready_i  (ready_i),
   .valid_o  (valid_o),
   .lo_idx_o (lo_idx_o),
   .hi_idx_o (hi_idx_o),
   .tw_idx_o (tw_idx_o),
   .last_o   (last_o)
);

// File: tb/bfs_sched_tb_top.sv
`timescale 1ns/1ps
module bfs_sched_tb_top;
   localparam int MAX_LOG2 = 6;
   localparam int CFG_W    = 3;
   localparam int IDX_W    = MAX_LOG2;
   localparam int TW_W     = MAX_LOG2 - 1;

   typedef struct packed {
      logic [IDX_W-1:0] lo;
      logic [IDX_W-1:0] hi;
      logic [TW_W-1:0]  tw;
      logic             last;
   } trip_t;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start_i = 1'b0;
   logic [CFG_W-1:0] log2n_i = '0;
   logic             ready_i = 1'b1;
   logic             valid_o, last_o, a_valid, a_last;
   logic [IDX_W-1:0] lo_idx_o, hi_idx_o, a_lo, a_hi;
   logic [TW_W-1:0]  tw_idx_o, a_tw;

   int    checks = 0;
   int    fails  = 0;
   int    seen   = 0;
   bit    stall_mode = 1'b0;
   bit    chk_drop = 1'b0;
   bit    prev_stall = 1'b0;
   trip_t prev_item;
   trip_t sb_q[$];
   logic [15:0] lfsr = 16'hACE1;

   always #4 clk = ~clk;

   bfs_sched #(.MAX_LOG2(MAX_LOG2), .CFG_W(CFG_W), .TW_MODE(bfs_pkg::TW_SHIFT)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .log2n_i(log2n_i), .ready_i(ready_i),
      .valid_o(valid_o), .lo_idx_o(lo_idx_o), .hi_idx_o(hi_idx_o),
      .tw_idx_o(tw_idx_o), .last_o(last_o));

   bfs_sched #(.MAX_LOG2(MAX_LOG2), .CFG_W(CFG_W), .TW_MODE(bfs_pkg::TW_ACCUM)) acc_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .log2n_i(log2n_i), .ready_i(ready_i),
      .valid_o(a_valid), .lo_idx_o(a_lo), .hi_idx_o(a_hi),
      .tw_idx_o(a_tw), .last_o(a_last));

   task automatic check(input bit ok, input string msg);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s", msg);
      end
   endtask

   // ready pattern: always high, or pseudo-random
   always @(posedge clk) begin
      #1;
      if (stall_mode) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         ready_i = lfsr[0];
      end else begin
         ready_i = 1'b1;
      end
   end

   // monitor: scoreboard pop and stall / end checks
   always @(negedge clk) begin
      if (rst_n) begin
         if (chk_drop) begin
            chk_drop = 1'b0;
            check(!valid_o, $sformatf("R7 valid after last: actual %0b expected 0", valid_o));
         end
         if (prev_stall) begin
            check(valid_o && {lo_idx_o, hi_idx_o, tw_idx_o, last_o} == prev_item,
                  $sformatf("R5 stalled item moved: actual %0b/%h expected 1/%h",
                            valid_o, {lo_idx_o, hi_idx_o, tw_idx_o, last_o}, prev_item));
         end
         if (valid_o && ready_i) begin
            trip_t got, exp;
            got = '{lo_idx_o, hi_idx_o, tw_idx_o, last_o};
            seen++;
            if (sb_q.size() == 0) begin
               check(1'b0, $sformatf("R3 extra item: actual lo=%0d hi=%0d expected none",
                                     lo_idx_o, hi_idx_o));
            end else begin
               exp = sb_q.pop_front();
               check(got == exp,
                     $sformatf("R3/R4/R6 item: actual lo=%0d hi=%0d tw=%0d last=%0b expected lo=%0d hi=%0d tw=%0d last=%0b",
                               got.lo, got.hi, got.tw, got.last, exp.lo, exp.hi, exp.tw, exp.last));
            end
            check(a_valid && {a_lo, a_hi, a_tw, a_last} == got,
                  $sformatf("R4 accumulating variant: actual tw=%0d expected tw=%0d", a_tw, got.tw));
            if (last_o) chk_drop = 1'b1;
         end
         prev_stall = valid_o && !ready_i;
         prev_item  = '{lo_idx_o, hi_idx_o, tw_idx_o, last_o};
      end
   end

   task automatic push_ref(input int lg);
      int n = 1 << lg;
      for (int size = 2; size <= n; size *= 2) begin
         int half = size / 2;
         int stride = n / size;
         for (int i = 0; i < n; i += size) begin
            int k = 0;
            for (int j = i; j < i + half; j++) begin
               trip_t t;
               t.lo   = IDX_W'(j);
               t.hi   = IDX_W'(j + half);
               t.tw   = TW_W'(k);
               t.last = (size == n) && (j == half - 1);
               sb_q.push_back(t);
               k += stride;
            end
         end
      end
   endtask

   task automatic run_case(input int lg, input bit disturb);
      int n = 1 << lg;
      push_ref(lg);
      seen = 0;
      @(posedge clk); #1;
      log2n_i = CFG_W'(lg);
      start_i = 1'b1;
      @(posedge clk); #1;
      start_i = 1'b0;
      if (disturb) log2n_i = CFG_W'((lg == 6) ? 2 : 6); // R10 change after capture
      @(negedge clk);
      check(valid_o && lo_idx_o == 0 && hi_idx_o == 1 && tw_idx_o == 0,
            $sformatf("R2 first item N=%0d: actual v=%0b lo=%0d hi=%0d tw=%0d expected 1/0/1/0",
                      n, valid_o, lo_idx_o, hi_idx_o, tw_idx_o));
      if (disturb) begin
         repeat (3) @(posedge clk);
         #1;
         start_i = 1'b1; // R8 start while busy
         log2n_i = CFG_W'(1);
         @(posedge clk); #1;
         start_i = 1'b0;
      end
      while (valid_o) @(negedge clk);
      @(negedge clk);
      check(sb_q.size() == 0 && seen == (n / 2) * lg,
            $sformatf("R6 count N=%0d: actual %0d expected %0d (left %0d)",
                      n, seen, (n / 2) * lg, sb_q.size()));
   endtask

   task automatic bad_start(input int code);
      @(posedge clk); #1;
      log2n_i = CFG_W'(code);
      start_i = 1'b1;
      @(posedge clk); #1;
      start_i = 1'b0;
      @(negedge clk);
      check(!valid_o, $sformatf("R9 code %0d: actual valid %0b expected 0", code, valid_o));
      @(negedge clk);
      check(!valid_o, $sformatf("R9 code %0d later: actual valid %0b expected 0", code, valid_o));
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      check(!valid_o && !last_o,
            $sformatf("R1 reset: actual v=%0b last=%0b expected 0/0", valid_o, last_o));
      bad_start(0);
      bad_start(7);
      for (int lg = 1; lg <= MAX_LOG2; lg++) run_case(lg, 1'b0);
      stall_mode = 1'b1;
      run_case(3, 1'b0);
      run_case(6, 1'b0);
      run_case(4, 1'b1);
      stall_mode = 1'b0;
      run_case(5, 1'b1);
      run_case(1, 1'b0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL R6 watchdog: actual run hung expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule